// File: doc/BRIEF.md
# Display Palette Lookup Unit

This block is the colour lookup stage of a display pipeline. Each pixel arrives as an 8-bit index with a valid strobe. One clock later the block returns a 24-bit RGB word taken from a table of 256 programmable entries. The table keeps each entry at 5/6/5 precision for red, green and blue. On the way out, every channel is widened back to 8 bits. A mono select input can instead send one widened grey level to all three channels.

Software reprograms the table through a small register port. It sets a programming request bit, then waits for the status bit to confirm that programming mode is active. It writes the entries and then clears the request. While programming mode is active, the pixel output is forced to black. An entry write made outside programming mode is dropped and sets a sticky error flag. Reading an entry back through the register port returns its widened colour form.

Top module: `pal_lut_top`

## Requirements
- R1: While reset is high and after it is released, `prog_req`, `prog_active`, `wr_err`, `pix_out_valid`, `pix_out`, `ent_rvalid` and `ent_rdata` are all zero. Reset is synchronous and active high.
- R2: The table has 256 entries, addressed by `ent_addr` for writes and reads and by `pix_idx` for lookups. Output words carry red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: An entry write keeps only write-data bits 23:19 (red), 15:10 (green) and 7:3 (blue). Bits 18:16, 9:8 and 2:0 have no effect on any later output.
- R4: On output, each stored field is widened to 8 bits by appending its missing low bits. Those low bits are all ones when the stored field is nonzero and all zeros when it is zero.
- R5: A control write (`req_wr` with `req_val`=1) sets `prog_req` at that clock edge. With the request held, `prog_active` reads 1 exactly three clock cycles after that edge.
- R6: A control write with `req_val`=0 clears `prog_req` at that edge, and `prog_active` reads 0 one cycle later. A request cleared before the three cycles have passed never raises `prog_active`.
- R7: A pixel sampled while `prog_active` is 1 produces `pix_out` equal to 0, whatever its index.
- R8: An entry write is stored only when `prog_active` is 1. An entry write at any other time leaves the table unchanged and sets `wr_err`, which then stays at 1 until reset.
- R9: A register read (`ent_rd`) returns, one cycle later, `ent_rvalid`=1 together with the widened colour form of the entry (R4). `mono_sel` has no effect on this read.
- R10: `pix_out_valid` is `pix_valid` delayed by one cycle, and `pix_out` is the lookup result for the index sampled with that strobe. When `pix_out_valid` is 0, `pix_out` is 0.
- R11: A pixel sampled with `mono_sel`=1 outputs the widened value of entry bits 7:3 on all three channels. Entry bits 23:8 then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Control register write strobe |
| req_val | input | 1 | Value written to the programming request bit |
| prog_req | output | 1 | Current programming request bit |
| prog_active | output | 1 | Status: programming mode active |
| ent_wr | input | 1 | Palette entry write strobe |
| ent_rd | input | 1 | Palette entry read strobe |
| ent_addr | input | 8 | Entry address for write or read |
| ent_wdata | input | 24 | Entry write data (R 23:16, G 15:8, B 7:0) |
| ent_rdata | output | 24 | Widened entry read data |
| ent_rvalid | output | 1 | Read data valid |
| wr_err | output | 1 | Sticky flag for a write made outside programming mode |
| mono_sel | input | 1 | 1: grey output, 0: colour output |
| pix_valid | input | 1 | Pixel index valid |
| pix_idx | input | 8 | Pixel index |
| pix_out | output | 24 | Registered RGB pixel data |
| pix_out_valid | output | 1 | Pixel data valid |

## Verification
The table is loaded with entries of several kinds. Some have data only in the discarded low bits, which separates truncation from plain storage. Some have a single least-significant kept bit per channel, which shows whether widening fills with ones or zeros. All ones, all zeros and hashed values make up the rest. Lookups sweep every index in colour mode and then a range in mono mode, so channel placement and grey replication are checked separately. The mode handshake is tried with a request held to completion, a request withdrawn after two cycles, pixels presented while programming is active, and a write attempted while it is inactive, which is then read back to confirm it had no effect.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int CH_W     = 8;
  localparam int PIX_W    = 3 * CH_W;
  localparam int RED_KEEP = 5;
  localparam int GRN_KEEP = 6;
  localparam int BLU_KEEP = 5;
  localparam int STORE_W  = RED_KEEP + GRN_KEEP + BLU_KEEP;

  typedef logic [STORE_W-1:0] pal_word_t;
  typedef logic [PIX_W-1:0]   rgb_t;

  function automatic pal_word_t pal_pack(input rgb_t w);
    return {w[PIX_W-1 -: RED_KEEP], w[2*CH_W-1 -: GRN_KEEP], w[CH_W-1 -: BLU_KEEP]};
  endfunction
endpackage

// File: rtl/pal_widen.sv
module pal_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  narrow,
  output logic [OUT_W-1:0] wide
);
  localparam int FILL_W = OUT_W - IN_W;

  generate
    if (FILL_W > 0) begin : g_fill
      assign wide = {narrow, {FILL_W{|narrow}}};
    end else begin : g_pass
      assign wide = narrow;
    end
  endgenerate
endmodule

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
(
  input  pal_word_t ent,
  input  logic      mono,
  output rgb_t      rgb
);
  logic [CH_W-1:0] r8, g8, b8;

  pal_widen #(.IN_W(RED_KEEP), .OUT_W(CH_W)) i_wr (
    .narrow(ent[STORE_W-1 -: RED_KEEP]), .wide(r8));
  pal_widen #(.IN_W(GRN_KEEP), .OUT_W(CH_W)) i_wg (
    .narrow(ent[BLU_KEEP +: GRN_KEEP]), .wide(g8));
  pal_widen #(.IN_W(BLU_KEEP), .OUT_W(CH_W)) i_wb (
    .narrow(ent[BLU_KEEP-1:0]), .wide(b8));

  assign rgb = mono ? {b8, b8, b8} : {r8, g8, b8};
endmodule

// File: rtl/pal_mode_seq.sv
module pal_mode_seq #(
  parameter int ENTER_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_wr,
  input  logic req_val,
  output logic en_o,
  output logic active_o
);
  localparam int CNT_W = $clog2(ENTER_LAT + 2);

  logic             en_q, active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (req_wr) en_q <= req_val;
      if (!en_q) begin
        active_q <= 1'b0;
      end else if (!active_q && cnt_q == CNT_W'(ENTER_LAT - 1)) begin
        active_q <= 1'b1;
      end
      if (!en_q || active_q) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o     = en_q;
  assign active_o = active_q;

  // checker counter: consecutive cycles with the request bit held
  logic [CNT_W-1:0] held_q;
  always_ff @(posedge clk) begin
    if (rst)                                held_q <= '0;
    else if (!en_q)                         held_q <= '0;
    else if (held_q != CNT_W'(ENTER_LAT+1)) held_q <= held_q + 1'b1;
  end

  // R5
  enter_lat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> (held_q == CNT_W'(ENTER_LAT)));

  // R6
  leave_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !active_q);
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  pal_word_t        wdata,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_addr,
  output pal_word_t        a_data,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_addr,
  output pal_word_t        b_data
);
  localparam int DEPTH = 1 << IDX_W;

  pal_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_data <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) b_data <= mem[b_addr];
  end
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
  import pal_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int ENTER_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_wr,
  input  logic             req_val,
  output logic             prog_req,
  output logic             prog_active,
  input  logic             ent_wr,
  input  logic             ent_rd,
  input  logic [IDX_W-1:0] ent_addr,
  input  logic [23:0]      ent_wdata,
  output logic [23:0]      ent_rdata,
  output logic             ent_rvalid,
  output logic             wr_err,
  input  logic             mono_sel,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [23:0]      pix_out,
  output logic             pix_out_valid
);
  logic      store_we;
  pal_word_t pix_raw, rd_raw;
  rgb_t      pix_rgb, rd_rgb;
  logic      blank_q, mono_q, pv_q, rv_q, err_q;

  // discarded low bits of each channel
  logic unused_low;
  assign unused_low = ^{ent_wdata[2*CH_W+CH_W-RED_KEEP-1:2*CH_W],
                        ent_wdata[CH_W+CH_W-GRN_KEEP-1:CH_W],
                        ent_wdata[CH_W-BLU_KEEP-1:0]};

  pal_mode_seq #(.ENTER_LAT(ENTER_LAT)) i_mode (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_val(req_val),
    .en_o(prog_req), .active_o(prog_active));

  assign store_we = ent_wr && prog_active;

  pal_store #(.IDX_W(IDX_W)) i_store (
    .clk(clk), .we(store_we), .waddr(ent_addr), .wdata(pal_pack(ent_wdata)),
    .a_en(pix_valid), .a_addr(pix_idx), .a_data(pix_raw),
    .b_en(ent_rd), .b_addr(ent_addr), .b_data(rd_raw));

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q <= 1'b0;
      mono_q  <= 1'b0;
      pv_q    <= 1'b0;
      rv_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pv_q <= pix_valid;
      rv_q <= ent_rd;
      if (pix_valid) begin
        blank_q <= prog_active;
        mono_q  <= mono_sel;
      end
      if (ent_wr && !prog_active) err_q <= 1'b1;
    end
  end

  pal_expand i_pix_exp (.ent(pix_raw), .mono(mono_q), .rgb(pix_rgb));
  pal_expand i_rd_exp  (.ent(rd_raw),  .mono(1'b0),   .rgb(rd_rgb));

  assign pix_out       = (pv_q && !blank_q) ? pix_rgb : '0;
  assign pix_out_valid = pv_q;
  assign ent_rdata     = rv_q ? rd_rgb : '0;
  assign ent_rvalid    = rv_q;
  assign wr_err        = err_q;

  // R7
  blank_out_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_active && pix_valid) |=> (pix_out == '0));

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ent_wr && !prog_active) |=> wr_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R10
  pix_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> pix_out_valid);

  // R10
  pix_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_out_valid |-> (pix_out == '0));

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ent_rd |=> ent_rvalid);

  // R4
  rd_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ent_rvalid |-> (ent_rdata[18:16] == {3{|ent_rdata[23:19]}}));
endmodule

// File: tb/test_pal_lut_top.sv
module test_pal_lut_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTER      = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_wr = 1'b0, req_val = 1'b0;
  logic        ent_wr = 1'b0, ent_rd = 1'b0;
  logic [7:0]  ent_addr = '0;
  logic [23:0] ent_wdata = '0;
  logic        mono_sel = 1'b0, pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        prog_req, prog_active, ent_rvalid, wr_err, pix_out_valid;
  logic [23:0] ent_rdata, pix_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit started = 0;

  pal_lut_top i_pal_lut_top (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_val(req_val),
    .prog_req(prog_req), .prog_active(prog_active),
    .ent_wr(ent_wr), .ent_rd(ent_rd), .ent_addr(ent_addr),
    .ent_wdata(ent_wdata), .ent_rdata(ent_rdata), .ent_rvalid(ent_rvalid),
    .wr_err(wr_err), .mono_sel(mono_sel), .pix_valid(pix_valid),
    .pix_idx(pix_idx), .pix_out(pix_out), .pix_out_valid(pix_out_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // widening rule written from R4 / R11
  function automatic int widen_rgb(input int w, input bit mono);
    int r, g, b, r8, g8, b8;
    r = (w >> 19) & 31;
    g = (w >> 10) & 63;
    b = (w >> 3) & 31;
    r8 = (r != 0) ? (r * 8 + 7) : 0;
    g8 = (g != 0) ? (g * 4 + 3) : 0;
    b8 = (b != 0) ? (b * 8 + 7) : 0;
    if (mono) return b8 * 65536 + b8 * 256 + b8;
    return r8 * 65536 + g8 * 256 + b8;
  endfunction

  function automatic int pattern(input int i);
    case (i)
      0: return 0;
      1: return 'h070307;
      2: return 'hFFFFFF;
      3: return 'h080400;
      4: return 'h000008;
      default: return (i * 'h9E3779 + 'h1234) & 'hFFFFFF;
    endcase
  endfunction

  // behavioural reference model
  int  m_mem [256];
  bit  m_en, m_act, m_err, m_pv, m_rv, m_pblank, m_pmono;
  int  m_since, m_pix, m_rd;

  always @(posedge clk) begin
    bit old_act, old_en;
    int old_since;
    if (rst) begin
      m_en = 0; m_act = 0; m_err = 0; m_pv = 0; m_rv = 0;
      m_since = 0; m_pix = 0; m_rd = 0; m_pblank = 0; m_pmono = 0;
    end else begin
      old_act = m_act; old_en = m_en; old_since = m_since;
      m_pv = pix_valid;
      m_pblank = old_act;
      m_pmono = mono_sel;
      m_pix = (pix_valid && !old_act) ? widen_rgb(m_mem[pix_idx], mono_sel) : 0;
      m_rv = ent_rd;
      m_rd = ent_rd ? widen_rgb(m_mem[ent_addr], 0) : 0;
      if (ent_wr) begin
        if (old_act) m_mem[ent_addr] = ent_wdata;
        else m_err = 1;
      end
      m_act = old_en && (old_act || (old_since + 1 >= ENTER));
      m_since = old_en ? old_since + 1 : 0;
      if (req_wr) m_en = req_val;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R5 prog_req", 32'(prog_req), 32'(m_en));
      chk("R5 R6 prog_active", 32'(prog_active), 32'(m_act));
      chk("R8 wr_err", 32'(wr_err), 32'(m_err));
      chk("R10 pix_out_valid", 32'(pix_out_valid), 32'(m_pv));
      if (!m_pv)         chk("R10 pix_out idle", 32'(pix_out), 32'(m_pix));
      else if (m_pblank) chk("R7 pix_out blank", 32'(pix_out), 32'(m_pix));
      else if (m_pmono)  chk("R11 pix_out mono", 32'(pix_out), 32'(m_pix));
      else               chk("R2 R3 R4 pix_out", 32'(pix_out), 32'(m_pix));
      chk("R9 ent_rvalid", 32'(ent_rvalid), 32'(m_rv));
      chk("R9 ent_rdata", 32'(ent_rdata), 32'(m_rd));
    end
  end

  task automatic cyc();
    @(negedge clk); #2;
    req_wr = 0; ent_wr = 0; ent_rd = 0; pix_valid = 0;
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask
  task automatic do_req(input bit v);
    cyc(); req_wr = 1; req_val = v;
  endtask
  task automatic do_write(input int a, input int d);
    cyc(); ent_wr = 1; ent_addr = 8'(a); ent_wdata = 24'(d);
  endtask
  task automatic do_read(input int a);
    cyc(); ent_rd = 1; ent_addr = 8'(a);
  endtask
  task automatic do_pix(input int i, input bit m);
    cyc(); pix_valid = 1; pix_idx = 8'(i); mono_sel = m;
  endtask

  initial begin
    started = 1;
    // R1: reset state while reset is held
    idle(2);
    @(negedge clk);
    chk("R1 reset prog_req", 32'(prog_req), 0);
    chk("R1 reset prog_active", 32'(prog_active), 0);
    chk("R1 reset wr_err", 32'(wr_err), 0);
    chk("R1 reset pix_out_valid", 32'(pix_out_valid), 0);
    chk("R1 reset outputs", 32'(pix_out) | 32'(ent_rdata) | 32'(ent_rvalid), 0);
    #2 rst = 0;
    idle(2);

    // R6: request withdrawn before entry completes, never active
    do_req(1); idle(1); do_req(0); idle(6);

    // R5: enter programming, pixels blanked (R7)
    do_req(1);
    do_pix(2, 0); do_pix(3, 0); idle(2); do_pix(2, 0); do_pix(5, 1);
    // R2 R3: program all entries
    for (int i = 0; i < 256; i++) do_write(i, pattern(i));
    do_read(2); do_read(1); do_read(3);
    // R6: leave programming mode
    do_req(0); do_pix(2, 0); idle(2);

    // R8: write outside programming mode is ignored and flagged
    do_write(5, 'hABCDEF); idle(1); do_read(5); idle(3);

    // R2 R4 R10: colour sweep of all indices
    for (int i = 0; i < 256; i++) do_pix(i, 0);
    // R11: mono lookups
    for (int i = 0; i < 40; i++) do_pix(i, 1);
    // R9: reads are unaffected by mono_sel
    for (int i = 0; i < 8; i++) begin do_read(i * 31); mono_sel = 1; end
    // gaps between pixels (R10)
    do_pix(2, 0); idle(1); do_pix(4, 0); idle(1); do_pix(3, 1);
    idle(5);
    finish_run();
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      finish_run();
    end
  end
endmodule